// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a byte-wide transmit path from a circular table of buffer descriptors kept in a small internal descriptor memory. Each descriptor holds a 16-bit control/status word, a 16-bit byte count and a 32-bit buffer address. Software loads descriptors and buffer bytes through write ports and sets the ready bit to hand a descriptor over. The engine fetches the descriptor at its current index. If ready is clear, it stays on that entry and polls it. If ready is set, it streams the buffer bytes, one per cycle, out of a register-array buffer memory.

A frame may span several buffers. Only the buffer flagged as last closes the frame. On that buffer the engine can append pad bytes up to a programmable minimum frame length, and it can raise a request for a downstream checksum stage to append a CRC. After each buffer it writes status back into the control word and clears ready in the same write. It then steps to the next entry, or returns to entry 0 after an entry that carries the wrap flag. It can also pulse a per-buffer event.

Top module: `txr_engine`

Control word bits used below: 15 ready, 14 pad, 13 wrap, 12 irq, 11 last, 10 crc, 1 padded (status), 0 ring-error (status). Bits 9..2 belong to software and are carried through unchanged.

## Requirements
- R1: After synchronous reset, `tx_valid`, `tx_eof`, `tx_crc_req`, `evt_done` and `evt_err` are 0, `cur_idx` is 0, and every descriptor control word reads 0.
- R2: While `enable` is 0, or while the descriptor at `cur_idx` has ready (bit 15) equal to 0, no byte is emitted and `cur_idx` does not change. Once ready becomes 1 with `enable` high, that same descriptor is processed.
- R3: A processed descriptor with length L emits exactly L bytes on consecutive cycles with `tx_valid` high. Byte i is the buffer memory byte at address (pointer + i) modulo `BUF_BYTES`.
- R4: `tx_eof` is high only with the final byte of a buffer whose last bit (bit 11) is 1. A buffer with last equal to 0 never asserts `tx_eof`, and its frame continues into the next descriptor.
- R5: On a last buffer with pad (bit 14) set, if the frame length counted over all its buffers is below `min_len`, bytes equal to `pad_byte` follow the data until the frame length equals `min_len`. `tx_eof` then marks the final pad byte.
- R6: The pad bit has no effect on a buffer whose last bit is 0, nor on a frame already at or above `min_len`.
- R7: `tx_crc_req` pulses for one cycle in the cycle after a buffer finishes, only when that buffer has both last and crc (bit 10) set. The crc bit is ignored on non-last buffers.
- R8: On completion, the control word is rewritten in a single write. Ready is cleared, bits 14..2 are kept, bit 1 is set exactly when pad bytes were added for that buffer, and bit 0 is set exactly on a ring error.
- R9: After a descriptor with wrap (bit 13) set, the next index is 0. Otherwise the index advances by one, and it also returns to 0 after index `NUM_DESC`-1.
- R10: A ready descriptor at index 0 with wrap set is a ring error. No byte is emitted, the descriptor is written back with ready cleared and bit 0 set, and the index stays 0.
- R11: When irq (bit 12) is set, `evt_done` pulses once per completed buffer without error, and `evt_err` pulses instead on a ring error. When irq is clear, neither pulses. The two never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows descriptor fetches |
| min_len | input | 16 | Minimum frame length target for padding |
| pad_byte | input | 8 | Value of each inserted pad byte |
| dsc_we | input | 1 | Descriptor write strobe |
| dsc_widx | input | IW | Descriptor index to write |
| dsc_wctrl | input | 16 | Control word to write |
| dsc_wlen | input | 16 | Byte count to write |
| dsc_wptr | input | 32 | Buffer address to write |
| dsc_ridx | input | IW | Descriptor index to read back |
| dsc_rctrl | output | 16 | Control word at `dsc_ridx` |
| buf_we | input | 1 | Buffer memory write strobe |
| buf_waddr | input | BUF_AW | Buffer memory byte address |
| buf_wdata | input | 8 | Buffer memory write byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_eof | output | 1 | Final byte of a frame |
| tx_crc_req | output | 1 | One-cycle request to append a CRC |
| evt_done | output | 1 | Buffer serviced event |
| evt_err | output | 1 | Buffer ended in error event |
| cur_idx | output | IW | Descriptor index being serviced |

## Verification
The bench builds the engine with the default eight descriptors and a 256-byte buffer memory. Rings of two to eight entries therefore reach both an early wrap flag and the hardware end of the table. Buffer addresses are random 32-bit values, so reads roll over the end of the 256-byte array. Minimum lengths up to 40 against buffers of up to 12 bytes make padding happen both inside one buffer and across multi-buffer frames, and make it absent when the frame is already long enough.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int CTRL_W   = 16;
    localparam int LEN_W    = 16;
    localparam int PTR_W    = 32;

    // Control word bit positions (software-visible layout)
    localparam int B_READY  = 15;
    localparam int B_PAD    = 14;
    localparam int B_WRAP   = 13;
    localparam int B_IRQ    = 12;
    localparam int B_LAST   = 11;
    localparam int B_CRC    = 10;
    localparam int B_PADDED = 1;
    localparam int B_RINGER = 0;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [LEN_W-1:0]  len;
        logic [PTR_W-1:0]  ptr;
    } txd_t;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DATA,
        ST_PAD,
        ST_WB
    } txr_state_e;

    // Status-bearing word written back when a buffer completes
    function automatic logic [CTRL_W-1:0] done_word(
        input logic [CTRL_W-1:0] c,
        input logic              padded,
        input logic              ring_err
    );
        logic [CTRL_W-1:0] w;
        w           = c;
        w[B_READY]  = 1'b0;
        w[B_PADDED] = padded;
        w[B_RINGER] = ring_err;
        return w;
    endfunction

    // Padding applies only on a last buffer that asks for it and is short
    function automatic logic needs_pad(
        input logic [CTRL_W-1:0] c,
        input logic [LEN_W-1:0]  frame_len,
        input logic [LEN_W-1:0]  target
    );
        return c[B_LAST] && c[B_PAD] && (frame_len < target);
    endfunction

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem
    import txr_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IW       = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IW-1:0]     host_idx,
    input  txd_t              host_desc,
    input  logic [IW-1:0]     eng_idx,
    output txd_t              eng_desc,
    input  logic              wb_en,
    input  logic [IW-1:0]     wb_idx,
    input  logic [CTRL_W-1:0] wb_ctrl,
    input  logic [IW-1:0]     rd_idx,
    output logic [CTRL_W-1:0] rd_ctrl
);

    txd_t table_q [NUM_DESC];

    // Host write placed last so it wins over a same-entry writeback
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                table_q[i] <= '0;
            end
        end else begin
            if (wb_en) begin
                table_q[wb_idx].ctrl <= wb_ctrl;
            end
            if (host_we) begin
                table_q[host_idx] <= host_desc;
            end
        end
    end

    assign eng_desc = table_q[eng_idx];
    assign rd_ctrl  = table_q[rd_idx].ctrl;

    // Writeback must leave the entry owned by software
    logic          chk_pend;
    logic [IW-1:0] chk_idx;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_pend <= 1'b0;
            chk_idx  <= '0;
        end else begin
            chk_pend <= wb_en && !(host_we && host_idx == wb_idx);
            chk_idx  <= wb_idx;
        end
    end

    assert_ready_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        chk_pend |-> !table_q[chk_idx].ctrl[B_READY]);

endmodule

// File: rtl/txr_buf_mem.sv
module txr_buf_mem #(
    parameter int BUF_BYTES = 256,
    parameter int BUF_AW    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [BUF_AW-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] bytes_q [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            bytes_q[waddr] <= wdata;
        end
    end

    assign rdata = bytes_q[raddr];

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IW       = $clog2(NUM_DESC),
    parameter int BUF_AW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LEN_W-1:0]  min_len,
    input  logic [7:0]        pad_byte,
    input  txd_t              desc,
    output logic [IW-1:0]     idx,
    output logic              wb_en,
    output logic [IW-1:0]     wb_idx,
    output logic [CTRL_W-1:0] wb_ctrl,
    output logic [BUF_AW-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_eof,
    output logic              crc_req,
    output logic              evt_done,
    output logic              evt_err
);

    txr_state_e        state;
    logic [CTRL_W-1:0] cur_ctrl;
    logic [LEN_W-1:0]  cur_len;
    logic [PTR_W-1:0]  cur_ptr;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  flen;
    logic              padded;
    logic              ring_err;

    logic [LEN_W-1:0]  flen_nx;
    logic              final_byte;

    assign flen_nx    = flen + 16'd1;
    assign final_byte = (cnt == cur_len - 16'd1);
    assign buf_raddr  = cur_ptr[BUF_AW-1:0] + cnt[BUF_AW-1:0];

    assign wb_en   = (state == ST_WB);
    assign wb_idx  = idx;
    assign wb_ctrl = done_word(cur_ctrl, padded, ring_err);

    function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] i, input logic w);
        if (w || i == IW'(NUM_DESC - 1)) begin
            return '0;
        end
        return i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FETCH;
            idx      <= '0;
            cur_ctrl <= '0;
            cur_len  <= '0;
            cur_ptr  <= '0;
            cnt      <= '0;
            flen     <= '0;
            padded   <= 1'b0;
            ring_err <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_eof   <= 1'b0;
            crc_req  <= 1'b0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_eof   <= 1'b0;
            crc_req  <= 1'b0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
            case (state)
                ST_FETCH: begin
                    if (enable && desc.ctrl[B_READY]) begin
                        cur_ctrl <= desc.ctrl;
                        cur_len  <= desc.len;
                        cur_ptr  <= desc.ptr;
                        cnt      <= '0;
                        padded   <= 1'b0;
                        if (idx == '0 && desc.ctrl[B_WRAP]) begin
                            ring_err <= 1'b1;
                            state    <= ST_WB;
                        end else begin
                            ring_err <= 1'b0;
                            if (desc.len != '0) begin
                                state <= ST_DATA;
                            end else if (needs_pad(desc.ctrl, flen, min_len)) begin
                                state <= ST_PAD;
                            end else begin
                                state <= ST_WB;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    tx_valid <= 1'b1;
                    tx_data  <= buf_rdata;
                    cnt      <= cnt + 16'd1;
                    flen     <= flen_nx;
                    if (final_byte) begin
                        if (needs_pad(cur_ctrl, flen_nx, min_len)) begin
                            state <= ST_PAD;
                        end else begin
                            tx_eof <= cur_ctrl[B_LAST];
                            state  <= ST_WB;
                        end
                    end
                end
                ST_PAD: begin
                    tx_valid <= 1'b1;
                    tx_data  <= pad_byte;
                    flen     <= flen_nx;
                    padded   <= 1'b1;
                    if (flen_nx >= min_len) begin
                        tx_eof <= 1'b1;
                        state  <= ST_WB;
                    end
                end
                ST_WB: begin
                    crc_req  <= cur_ctrl[B_LAST] && cur_ctrl[B_CRC] && !ring_err;
                    evt_done <= cur_ctrl[B_IRQ] && !ring_err;
                    evt_err  <= cur_ctrl[B_IRQ] && ring_err;
                    idx      <= step_idx(idx, cur_ctrl[B_WRAP]);
                    if (cur_ctrl[B_LAST] || ring_err) begin
                        flen <= '0;
                    end
                    state <= ST_FETCH;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

    // End of frame is followed by the writeback gap, never by another byte
    assert_eof_closes_R4: assert property (@(posedge clk) disable iff (rst)
        tx_eof |=> !tx_valid);

    // Pad bytes are only produced while the frame is short of the target
    assert_pad_short_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD) |-> (flen < min_len));

    // CRC request only follows the writeback of a last buffer
    assert_crc_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        crc_req |-> ($past(state == ST_WB) && $past(cur_ctrl[B_LAST])));

    // Index only moves at writeback
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WB) |=> (idx == $past(idx)));

    // Done and error events are exclusive
    assert_evt_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(evt_done && evt_err));

endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int NUM_DESC  = 8,
    parameter int BUF_BYTES = 256,
    localparam int IW       = $clog2(NUM_DESC),
    localparam int BUF_AW   = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [15:0]       min_len,
    input  logic [7:0]        pad_byte,
    input  logic              dsc_we,
    input  logic [IW-1:0]     dsc_widx,
    input  logic [15:0]       dsc_wctrl,
    input  logic [15:0]       dsc_wlen,
    input  logic [31:0]       dsc_wptr,
    input  logic [IW-1:0]     dsc_ridx,
    output logic [15:0]       dsc_rctrl,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_waddr,
    input  logic [7:0]        buf_wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_eof,
    output logic              tx_crc_req,
    output logic              evt_done,
    output logic              evt_err,
    output logic [IW-1:0]     cur_idx
);

    txd_t              host_desc;
    txd_t              eng_desc;
    logic              wb_en;
    logic [IW-1:0]     wb_idx;
    logic [CTRL_W-1:0] wb_ctrl;
    logic [BUF_AW-1:0] buf_raddr;
    logic [7:0]        buf_rdata;

    assign host_desc = '{ctrl: dsc_wctrl, len: dsc_wlen, ptr: dsc_wptr};

    txr_desc_mem #(.NUM_DESC(NUM_DESC), .IW(IW)) u_desc (
        .clk       (clk),
        .rst       (rst),
        .host_we   (dsc_we),
        .host_idx  (dsc_widx),
        .host_desc (host_desc),
        .eng_idx   (cur_idx),
        .eng_desc  (eng_desc),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_ctrl   (wb_ctrl),
        .rd_idx    (dsc_ridx),
        .rd_ctrl   (dsc_rctrl)
    );

    txr_buf_mem #(.BUF_BYTES(BUF_BYTES), .BUF_AW(BUF_AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    txr_ctrl #(.NUM_DESC(NUM_DESC), .IW(IW), .BUF_AW(BUF_AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .min_len   (min_len),
        .pad_byte  (pad_byte),
        .desc      (eng_desc),
        .idx       (cur_idx),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_ctrl   (wb_ctrl),
        .buf_raddr (buf_raddr),
        .buf_rdata (buf_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_eof    (tx_eof),
        .crc_req   (tx_crc_req),
        .evt_done  (evt_done),
        .evt_err   (evt_err)
    );

endmodule

// File: tb/txr_engine_test.sv
module txr_engine_test;
    import txr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ND = 8;
    localparam int NB = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] min_len = '0;
    logic [7:0]  pad_byte = '0;
    logic        dsc_we = 1'b0;
    logic [2:0]  dsc_widx = '0;
    logic [15:0] dsc_wctrl = '0;
    logic [15:0] dsc_wlen = '0;
    logic [31:0] dsc_wptr = '0;
    logic [2:0]  dsc_ridx = '0;
    logic [15:0] dsc_rctrl;
    logic        buf_we = 1'b0;
    logic [7:0]  buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        tx_valid, tx_eof, tx_crc_req, evt_done, evt_err;
    logic [7:0]  tx_data;
    logic [2:0]  cur_idx;

    txr_engine #(.NUM_DESC(ND), .BUF_BYTES(NB)) uut (
        .clk(clk), .rst(rst), .enable(enable), .min_len(min_len), .pad_byte(pad_byte),
        .dsc_we(dsc_we), .dsc_widx(dsc_widx), .dsc_wctrl(dsc_wctrl), .dsc_wlen(dsc_wlen),
        .dsc_wptr(dsc_wptr), .dsc_ridx(dsc_ridx), .dsc_rctrl(dsc_rctrl),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_eof(tx_eof), .tx_crc_req(tx_crc_req),
        .evt_done(evt_done), .evt_err(evt_err), .cur_idx(cur_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor, sampled at the falling edge
    logic [7:0] got_b [$];
    bit         got_e [$];
    int         got_crc [$];
    int         n_done = 0;
    int         n_err  = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid) begin
                got_b.push_back(tx_data);
                got_e.push_back(tx_eof);
            end
            if (tx_crc_req) got_crc.push_back(got_b.size());
            if (evt_done) n_done++;
            if (evt_err)  n_err++;
        end
    end

    // Reference model state
    logic [7:0]  bm [NB];
    logic [15:0] d_ctrl [ND];
    logic [15:0] d_len  [ND];
    logic [31:0] d_ptr  [ND];
    logic [15:0] d_wb   [ND];
    logic [7:0]  exp_b [$];
    bit          exp_e [$];
    bit          exp_p [$];
    int          exp_crc [$];

    task automatic put_buf(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = 8'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic put_desc(input int i, input logic [15:0] c, input logic [15:0] l, input logic [31:0] p);
        @(negedge clk);
        dsc_we = 1'b1; dsc_widx = 3'(i); dsc_wctrl = c; dsc_wlen = l; dsc_wptr = p;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    task automatic clear_mon();
        got_b.delete(); got_e.delete(); got_crc.delete();
        exp_b.delete(); exp_e.delete(); exp_p.delete(); exp_crc.delete();
    endtask

    // mode 0: plain, 1: entry 0 first left unready, 2: engine disabled while loading
    task automatic run_ring(input int k, input int mode);
        int flen_m, nd0, ne0, want_done, emitted, wait_cyc;
        logic [15:0] c;
        bit padded;
        min_len  = 16'($urandom_range(0, 40));
        pad_byte = 8'($urandom);
        for (int a = 0; a < NB; a++) begin
            bm[a] = 8'($urandom);
            put_buf(a, bm[a]);
        end
        clear_mon();
        flen_m = 0;
        want_done = 0;
        for (int i = 0; i < k; i++) begin
            c = 16'($urandom) & 16'h03FF;
            c[B_READY] = 1'b1;
            c[B_PAD]   = 1'($urandom);
            c[B_IRQ]   = 1'($urandom);
            c[B_CRC]   = 1'($urandom);
            c[B_LAST]  = (i == k - 1) ? 1'b1 : ($urandom_range(0, 2) == 0);
            c[B_WRAP]  = (i == k - 1);
            d_ctrl[i] = c;
            d_len[i]  = 16'($urandom_range(0, 12));
            d_ptr[i]  = $urandom;
            emitted = 0;
            padded  = 0;
            for (int j = 0; j < int'(d_len[i]); j++) begin
                exp_b.push_back(bm[(d_ptr[i] + 32'(j)) % NB]);
                exp_e.push_back(1'b0); exp_p.push_back(1'b0);
                flen_m++; emitted++;
            end
            if (c[B_LAST] && c[B_PAD]) begin
                while (flen_m < int'(min_len)) begin
                    exp_b.push_back(pad_byte);
                    exp_e.push_back(1'b0); exp_p.push_back(1'b1);
                    flen_m++; emitted++; padded = 1;
                end
            end
            if (c[B_LAST] && emitted > 0) exp_e[exp_e.size() - 1] = 1'b1;
            if (c[B_LAST] && c[B_CRC]) exp_crc.push_back(exp_b.size());
            if (c[B_IRQ]) want_done++;
            if (c[B_LAST]) flen_m = 0;
            d_wb[i] = (c & 16'h7FFC) | (padded ? 16'h0002 : 16'h0000);
        end
        nd0 = n_done; ne0 = n_err;
        if (mode == 2) enable = 1'b0;
        for (int i = k - 1; i >= 1; i--) put_desc(i, d_ctrl[i], d_len[i], d_ptr[i]);
        if (mode == 1) begin
            put_desc(0, d_ctrl[0] & 16'h7FFF, d_len[0], d_ptr[0]);
            repeat (20) @(negedge clk);
            chk(got_b.size() == 0, "R2 unready entry emitted bytes", got_b.size(), 0);
            chk(cur_idx == 3'd0, "R2 index moved on unready entry", int'(cur_idx), 0);
        end
        put_desc(0, d_ctrl[0], d_len[0], d_ptr[0]);
        if (mode == 2) begin
            repeat (20) @(negedge clk);
            chk(got_b.size() == 0, "R2 disabled engine emitted bytes", got_b.size(), 0);
            enable = 1'b1;
        end
        wait_cyc = exp_b.size() + 3 * k + 20;
        repeat (wait_cyc) @(negedge clk);
        chk(got_b.size() == exp_b.size(), "R6 frame byte count", got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++) begin
            if (exp_p[i]) chk(got_b[i] == exp_b[i], "R5 pad byte", int'(got_b[i]), int'(exp_b[i]));
            else          chk(got_b[i] == exp_b[i], "R3 data byte", int'(got_b[i]), int'(exp_b[i]));
            chk(got_e[i] == exp_e[i], "R4 end of frame flag", int'(got_e[i]), int'(exp_e[i]));
        end
        chk(got_crc.size() == exp_crc.size(), "R7 crc request count", got_crc.size(), exp_crc.size());
        for (int i = 0; i < exp_crc.size() && i < got_crc.size(); i++)
            chk(got_crc[i] == exp_crc[i], "R7 crc request position", got_crc[i], exp_crc[i]);
        chk(n_done - nd0 == want_done, "R11 done events", n_done - nd0, want_done);
        chk(n_err == ne0, "R11 error events", n_err - ne0, 0);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            dsc_ridx = 3'(i);
            #1;
            chk(dsc_rctrl == d_wb[i], "R8 writeback word", int'(dsc_rctrl), int'(d_wb[i]));
        end
        chk(cur_idx == 3'd0, "R9 index after wrap", int'(cur_idx), 0);
    endtask

    task automatic ring_error(input bit irq);
        int nd0, ne0;
        logic [15:0] c, w;
        c = (16'($urandom) & 16'h03FF) | 16'hA800;
        c[B_IRQ] = irq;
        w = (c & 16'h7FFC) | 16'h0001;
        clear_mon();
        nd0 = n_done; ne0 = n_err;
        put_desc(0, c, 16'd5, $urandom);
        repeat (15) @(negedge clk);
        chk(got_b.size() == 0, "R10 bytes on ring error", got_b.size(), 0);
        dsc_ridx = 3'd0;
        #1;
        chk(dsc_rctrl == w, "R10 ring error writeback", int'(dsc_rctrl), int'(w));
        chk(cur_idx == 3'd0, "R10 index after ring error", int'(cur_idx), 0);
        chk(n_err - ne0 == int'(irq), "R11 error event", n_err - ne0, int'(irq));
        chk(n_done == nd0, "R11 no done event on error", n_done - nd0, 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 19000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);
        chk(tx_eof == 1'b0 && tx_crc_req == 1'b0, "R1 frame flags after reset", int'({tx_eof, tx_crc_req}), 0);
        chk(evt_done == 1'b0 && evt_err == 1'b0, "R1 events after reset", int'({evt_done, evt_err}), 0);
        chk(cur_idx == 3'd0, "R1 index after reset", int'(cur_idx), 0);
        for (int i = 0; i < ND; i++) begin
            dsc_ridx = 3'(i);
            #1;
            chk(dsc_rctrl == 16'h0, "R1 descriptor cleared", int'(dsc_rctrl), 0);
        end
        run_ring(3, 2);
        enable = 1'b1;
        run_ring(2, 1);
        ring_error(1'b1);
        ring_error(1'b0);
        run_ring(ND, 0);
        for (int r = 0; r < 22; r++) begin
            run_ring($urandom_range(2, ND), int'($urandom_range(0, 1)));
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule